// File: doc/BRIEF.md
# Video-Mode Packet Request Scheduler

This block sits between a pixel-timing source and the packet builder of a serial display link transmitter. It watches horizontal sync, vertical sync and data-enable, all in the clock domain of this block, and turns them into an ordered stream of packet requests. Each request carries a 6-bit data type, a 2-bit virtual channel and a 16-bit word count. The downstream packet builder takes a request through a valid/ready handshake and uses it to form the header and fetch payload. It adds the error-check fields and spreads the bytes over the lanes. This block does none of that work.

Sync edges become short sync packets. Which edges produce packets depends on the chosen ordering mode: paired start/end packets, or start packets only. Active pixels on the lines of the vertical active window are counted and cut into pixel-stream requests of at most a programmed number of pixels. The requests are sized for the chosen pixel format. After the last pixel request of a line, a blanking or null filler request can follow. The filler length depends on the horizontal timing. The filler can also be left out so that the link idles in low power. Events that arrive together are queued by a fixed priority. A small request queue absorbs short stalls on the downstream side.

Top module: `dvs_video_sched`

## Requirements
- R1: In the first cycle after synchronous reset is released, `pkt_valid` is low, and it stays low until a sync or data-enable event occurs.
- R2: `cfg_hs_pol` and `cfg_vs_pol` give the active level of each sync input: 1 means active high and 0 means active low. Leading and trailing edges are taken on the active level, never on the raw pin level.
- R3: A VSYNC leading edge produces a request of type 0x01, word count 0. When an HSYNC leading edge falls in the same cycle, only the 0x01 request is issued for that edge pair.
- R4: An HSYNC leading edge that does not coincide with a VSYNC leading edge produces a request of type 0x21, word count 0.
- R5: In mode 0 (`cfg_mode` = 0, sync pulses), a VSYNC trailing edge adds type 0x11 and an HSYNC trailing edge adds type 0x31, both with word count 0. Modes 1, 2 and 3 never produce 0x11 or 0x31.
- R6: The vertical window is defined by line numbering. Lines are numbered from 0 at the first HSYNC leading edge on or after a VSYNC trailing edge. Data-enable is honoured only on lines whose number n satisfies `cfg_vbp` <= n < `cfg_vbp` + `cfg_height`. Before the first VSYNC trailing edge after reset, no line is in the window. Data-enable on any other line produces no request at all.
- R7: Along an active data-enable run, a pixel request is issued each time `cfg_chunk` pixels have been counted. When the run ends with a partial count, one more request is issued for the remaining pixels.
- R8: The pixel request type and word count follow `cfg_fmt`. For n pixels: code 0 gives type 0x0E with 2n bytes, code 1 gives 0x1E with floor(9n/4) bytes, code 2 gives 0x2E with 3n bytes, and code 3 gives 0x3E with 3n bytes.
- R9: After an honoured data-enable run ends, a filler request follows the pixel requests. `cfg_fill` = 1 gives type 0x19 and `cfg_fill` = 2 gives type 0x09. `cfg_fill` = 0 or 3 gives no filler. The filler word count is `cfg_hfp` in modes 0, 1 and 3, and `cfg_hsw` + `cfg_hbp` + `cfg_hfp` in mode 2 (burst).
- R10: Requests leave in the order of their events. Events in the same cycle are ordered 0x01, then 0x11, then 0x21, then 0x31, then pixel, then filler.
- R11: Every request carries `cfg_vc` in `pkt_vc`.
- R12: While `pkt_valid` is high and `pkt_ready` is low, all request fields hold steady. As long as the queue of `FIFO_DEPTH` entries does not fill, back-pressure neither loses nor duplicates a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the pixel timing |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, polarity per `cfg_hs_pol` |
| vsync_in | input | 1 | Vertical sync, polarity per `cfg_vs_pol` |
| de_in | input | 1 | Data enable, active high, one pixel per cycle |
| cfg_mode | input | 2 | 0 sync pulses, 1 sync events, 2 burst, 3 as 1 |
| cfg_fill | input | 2 | Filler policy: 0 low power, 1 blanking, 2 null, 3 low power |
| cfg_fmt | input | 2 | Pixel format code |
| cfg_vc | input | 2 | Virtual channel for all requests |
| cfg_hs_pol | input | 1 | HSYNC active level |
| cfg_vs_pol | input | 1 | VSYNC active level |
| cfg_hsw | input | H_W | Horizontal sync width, pixel clocks |
| cfg_hbp | input | H_W | Horizontal back porch, pixel clocks |
| cfg_hfp | input | H_W | Horizontal front porch, pixel clocks |
| cfg_vbp | input | LINE_W | Vertical back porch, lines |
| cfg_height | input | LINE_W | Active line count |
| cfg_chunk | input | PX_W | Maximum pixels per pixel request |
| pkt_valid | output | 1 | Request present |
| pkt_ready | input | 1 | Downstream accepts the request |
| pkt_dt | output | 6 | Request data type |
| pkt_vc | output | 2 | Request virtual channel |
| pkt_wc | output | 16 | Request word count |

## Verification
The assertions assume that the configuration is changed only while the block is idle and the queue is empty. They assume data-enable is low at every HSYNC leading edge. They also assume that events keep far enough apart that no kind of event is raised again before its earlier occurrence has entered the queue. The assertions also assume the downstream side drains the queue fast enough that it never overflows. The stimulus keeps within these limits. It changes the configuration only between drained frames, and holds sync widths and porches at several cycles so that simultaneous events clear before the next ones. It also never stalls `pkt_ready` for more than one cycle in four while chunks of at least two pixels are sent. Vertical sync edges are made to coincide with horizontal leading edges, so the same-cycle ordering and the line numbering reset are both exercised.

// File: rtl/dvs_pkg.sv
package dvs_pkg;

  localparam logic [5:0] DT_VSS   = 6'h01;
  localparam logic [5:0] DT_VSE   = 6'h11;
  localparam logic [5:0] DT_HSS   = 6'h21;
  localparam logic [5:0] DT_HSE   = 6'h31;
  localparam logic [5:0] DT_BLANK = 6'h19;
  localparam logic [5:0] DT_NULL  = 6'h09;

  typedef enum logic [1:0] {
    VM_PULSE = 2'd0,
    VM_EVENT = 2'd1,
    VM_BURST = 2'd2,
    VM_ALT   = 2'd3
  } vmode_e;

  typedef enum logic [1:0] {
    FL_LP    = 2'd0,
    FL_BLANK = 2'd1,
    FL_NULL  = 2'd2,
    FL_ALT   = 2'd3
  } fill_e;

  typedef struct packed {
    logic [1:0]  vc;
    logic [5:0]  dt;
    logic [15:0] wc;
  } pkt_t;

  // Pixel stream data type: format code in the upper two bits, 0xE below.
  function automatic logic [5:0] pix_dt(input logic [1:0] fmt);
    return {fmt, 4'hE};
  endfunction

  // Payload bytes for px pixels of the given format code.
  function automatic logic [15:0] pix_wc(input logic [1:0] fmt, input logic [15:0] px);
    logic [15:0] r;
    case (fmt)
      2'd0:    r = px << 1;
      2'd1:    r = (px * 16'd9) >> 2;
      default: r = px * 16'd3;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dvs_sync_edge.sv
module dvs_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic act_high,
  output logic lead,
  output logic trail
);

  logic lvl_q;
  logic lvl_d1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      lvl_d1 <= 1'b0;
    end else begin
      lvl_q  <= act_high ? raw : ~raw;
      lvl_d1 <= lvl_q;
    end
  end

  assign lead  = lvl_q & ~lvl_d1;
  assign trail = ~lvl_q & lvl_d1;

endmodule

// File: rtl/dvs_line_track.sv
module dvs_line_track #(
  parameter int LINE_W = 12,
  parameter int PX_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_lead,
  input  logic              vs_trail,
  input  logic              de_raw,
  input  logic [LINE_W-1:0] cfg_vbp,
  input  logic [LINE_W-1:0] cfg_height,
  input  logic [PX_W-1:0]   cfg_chunk,
  output logic              pix_evt,
  output logic [PX_W-1:0]   pix_n,
  output logic              run_end
);

  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] idx;
  logic [LINE_W:0]   win_end;
  logic              line_on;
  logic              de_q;
  logic              de_on;
  logic              de_was;
  logic [PX_W-1:0]   px_cnt;
  logic [PX_W-1:0]   px_inc;

  assign idx     = vs_trail ? '0 : line_cnt;
  assign win_end = {1'b0, cfg_vbp} + {1'b0, cfg_height};
  assign de_on   = de_q & line_on;
  assign px_inc  = px_cnt + 1'b1;

  // Line numbering: restart at the vertical trailing edge, saturate at the top.
  always_ff @(posedge clk) begin
    if (rst) begin
      line_cnt <= '1;
      line_on  <= 1'b0;
    end else if (hs_lead) begin
      line_on  <= (idx >= cfg_vbp) && ({1'b0, idx} < win_end);
      line_cnt <= (idx == '1) ? idx : idx + 1'b1;
    end else if (vs_trail) begin
      line_cnt <= '0;
    end
  end

  // Pixel chunking along one data-enable run.
  always_ff @(posedge clk) begin
    if (rst) begin
      de_q    <= 1'b0;
      de_was  <= 1'b0;
      px_cnt  <= '0;
      pix_evt <= 1'b0;
      pix_n   <= '0;
      run_end <= 1'b0;
    end else begin
      de_q    <= de_raw;
      de_was  <= de_on;
      pix_evt <= 1'b0;
      run_end <= 1'b0;
      if (de_on) begin
        if (px_inc == cfg_chunk) begin
          pix_evt <= 1'b1;
          pix_n   <= cfg_chunk;
          px_cnt  <= '0;
        end else begin
          px_cnt <= px_inc;
        end
      end else if (de_was) begin
        if (px_cnt != '0) begin
          pix_evt <= 1'b1;
          pix_n   <= px_cnt;
        end
        run_end <= 1'b1;
        px_cnt  <= '0;
      end
    end
  end

  AST_DE_LOW_AT_LINE_START: assert property (@(posedge clk) disable iff (rst)
    hs_lead |-> !de_q); // R6

endmodule

// File: rtl/dvs_req_fifo.sv
module dvs_req_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr;
  logic [AW:0]  rd_ptr;
  logic         empty;
  logic         pop;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign pop   = !empty && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (pop) out_data <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_en && !full) wr_ptr <= wr_ptr + 1'b1;
      if (pop) begin
        rd_ptr    <= rd_ptr + 1'b1;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full); // R12

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R12

endmodule

// File: rtl/dvs_video_sched.sv
module dvs_video_sched
  import dvs_pkg::*;
#(
  parameter int LINE_W     = 12,
  parameter int PX_W       = 12,
  parameter int H_W        = 12,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              de_in,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_fill,
  input  logic [1:0]        cfg_fmt,
  input  logic [1:0]        cfg_vc,
  input  logic              cfg_hs_pol,
  input  logic              cfg_vs_pol,
  input  logic [H_W-1:0]    cfg_hsw,
  input  logic [H_W-1:0]    cfg_hbp,
  input  logic [H_W-1:0]    cfg_hfp,
  input  logic [LINE_W-1:0] cfg_vbp,
  input  logic [LINE_W-1:0] cfg_height,
  input  logic [PX_W-1:0]   cfg_chunk,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [5:0]        pkt_dt,
  output logic [1:0]        pkt_vc,
  output logic [15:0]       pkt_wc
);

  localparam int NSYNC = 2;      // index 0 horizontal, 1 vertical
  localparam int NEV   = 6;      // pending event kinds, in priority order
  localparam int PW    = $bits(pkt_t);

  localparam int EV_VSS  = 0;
  localparam int EV_VSE  = 1;
  localparam int EV_HSS  = 2;
  localparam int EV_HSE  = 3;
  localparam int EV_PIX  = 4;
  localparam int EV_FILL = 5;

  logic [NSYNC-1:0] raw_v, pol_v, lead_v, trail_v;
  logic             hs_lead, hs_trail, vs_lead, vs_trail;
  logic             pix_evt, run_end;
  logic [PX_W-1:0]  pix_n;
  logic [PX_W-1:0]  pend_px;
  logic [NEV-1:0]   pend, set_v, clr_v, sel;
  logic             pulse_mode, fill_on, do_push, q_full;
  logic [15:0]      fill_wc;
  pkt_t             nxt_pkt;
  pkt_t             out_pkt;
  logic [PW-1:0]    out_bits;

  assign raw_v = {vsync_in, hsync_in};
  assign pol_v = {cfg_vs_pol, cfg_hs_pol};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    dvs_sync_edge u_edge (
      .clk      (clk),
      .rst      (rst),
      .raw      (raw_v[g]),
      .act_high (pol_v[g]),
      .lead     (lead_v[g]),
      .trail    (trail_v[g])
    );
  end

  assign hs_lead  = lead_v[0];
  assign hs_trail = trail_v[0];
  assign vs_lead  = lead_v[1];
  assign vs_trail = trail_v[1];

  dvs_line_track #(
    .LINE_W (LINE_W),
    .PX_W   (PX_W)
  ) u_track (
    .clk        (clk),
    .rst        (rst),
    .hs_lead    (hs_lead),
    .vs_trail   (vs_trail),
    .de_raw     (de_in),
    .cfg_vbp    (cfg_vbp),
    .cfg_height (cfg_height),
    .cfg_chunk  (cfg_chunk),
    .pix_evt    (pix_evt),
    .pix_n      (pix_n),
    .run_end    (run_end)
  );

  assign pulse_mode = (cfg_mode == VM_PULSE);
  assign fill_on    = (cfg_fill == FL_BLANK) || (cfg_fill == FL_NULL);
  assign fill_wc    = (cfg_mode == VM_BURST) ? (16'(cfg_hsw) + 16'(cfg_hbp) + 16'(cfg_hfp))
                                             : 16'(cfg_hfp);

  always_comb begin
    set_v          = '0;
    set_v[EV_VSS]  = vs_lead;
    set_v[EV_VSE]  = vs_trail & pulse_mode;
    set_v[EV_HSS]  = hs_lead & ~vs_lead;
    set_v[EV_HSE]  = hs_trail & pulse_mode;
    set_v[EV_PIX]  = pix_evt;
    set_v[EV_FILL] = run_end & fill_on;
  end

  // Lowest set bit wins: that is the fixed priority order.
  assign sel     = pend & (~pend + 1'b1);
  assign do_push = (|pend) && !q_full;
  assign clr_v   = do_push ? sel : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      pend_px <= '0;
    end else begin
      pend <= (pend & ~clr_v) | set_v;
      if (pix_evt) pend_px <= pix_n;
    end
  end

  always_comb begin
    nxt_pkt    = '0;
    nxt_pkt.vc = cfg_vc;
    if (sel[EV_VSS]) begin
      nxt_pkt.dt = DT_VSS;
    end else if (sel[EV_VSE]) begin
      nxt_pkt.dt = DT_VSE;
    end else if (sel[EV_HSS]) begin
      nxt_pkt.dt = DT_HSS;
    end else if (sel[EV_HSE]) begin
      nxt_pkt.dt = DT_HSE;
    end else if (sel[EV_PIX]) begin
      nxt_pkt.dt = pix_dt(cfg_fmt);
      nxt_pkt.wc = pix_wc(cfg_fmt, 16'(pend_px));
    end else if (sel[EV_FILL]) begin
      nxt_pkt.dt = (cfg_fill == FL_BLANK) ? DT_BLANK : DT_NULL;
      nxt_pkt.wc = fill_wc;
    end
  end

  dvs_req_fifo #(
    .W     (PW),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (do_push),
    .wr_data   (nxt_pkt),
    .full      (q_full),
    .out_valid (pkt_valid),
    .out_data  (out_bits),
    .out_ready (pkt_ready)
  );

  assign out_pkt = pkt_t'(out_bits);
  assign pkt_dt  = out_pkt.dt;
  assign pkt_vc  = out_pkt.vc;
  assign pkt_wc  = out_pkt.wc;

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pkt_valid); // R1

  AST_NO_EVENT_LOSS: assert property (@(posedge clk) disable iff (rst)
    (set_v & pend & ~clr_v) == '0); // R10

  AST_END_ONLY_PULSE: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && (pkt_dt == DT_VSE || pkt_dt == DT_HSE)) |-> (cfg_mode == VM_PULSE)); // R5

  AST_FILL_POLICY: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && (pkt_dt == DT_BLANK || pkt_dt == DT_NULL)) |->
      (cfg_fill == ((pkt_dt == DT_BLANK) ? FL_BLANK : FL_NULL))); // R9

  AST_VC_MATCH: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (pkt_vc == cfg_vc)); // R11

endmodule

// File: tb/dvs_video_sched_bench.sv
module dvs_video_sched_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        hs = 1'b0, vs = 1'b0, de = 1'b0;
  logic [1:0]  c_mode = 2'd0, c_fill = 2'd0, c_fmt = 2'd0, c_vc = 2'd0;
  logic        c_hpol = 1'b1, c_vpol = 1'b1;
  logic [11:0] c_hsw = 12'd2, c_hbp = 12'd3, c_hfp = 12'd6;
  logic [11:0] c_vbp = 12'd0, c_height = 12'd1, c_chunk = 12'd4;
  logic        rdy = 1'b1;
  logic        pkt_valid;
  logic [5:0]  pkt_dt;
  logic [1:0]  pkt_vc;
  logic [15:0] pkt_wc;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit rdy_slow = 1'b0, hold_chk = 1'b0, done = 1'b0;
  logic [23:0] held;
  logic [23:0] exp_q[$];

  dvs_video_sched u_dvs_video_sched (
    .clk(clk), .rst(rst), .hsync_in(hs), .vsync_in(vs), .de_in(de),
    .cfg_mode(c_mode), .cfg_fill(c_fill), .cfg_fmt(c_fmt), .cfg_vc(c_vc),
    .cfg_hs_pol(c_hpol), .cfg_vs_pol(c_vpol),
    .cfg_hsw(c_hsw), .cfg_hbp(c_hbp), .cfg_hfp(c_hfp),
    .cfg_vbp(c_vbp), .cfg_height(c_height), .cfg_chunk(c_chunk),
    .pkt_valid(pkt_valid), .pkt_ready(rdy),
    .pkt_dt(pkt_dt), .pkt_vc(pkt_vc), .pkt_wc(pkt_wc)
  );

  function automatic string tag_of(logic [5:0] dt);
    case (dt)
      6'h01:        return "R3 R2";
      6'h21:        return "R4 R2";
      6'h11, 6'h31: return "R5";
      6'h19, 6'h09: return "R9";
      default:      return "R7 R8";
    endcase
  endfunction

  function automatic int bytes_for(int fmt, int px);
    if (fmt == 0) return 2 * px;
    if (fmt == 1) return (px * 18) / 8;
    return 3 * px;
  endfunction

  task automatic expect_pkt(int dt, int wc);
    exp_q.push_back({c_vc, 6'(dt), 16'(wc)});
  endtask

  task automatic note(bit ok, string req, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual vc=%0d dt=%h wc=%0d expected vc=%0d dt=%h wc=%0d",
               req, act[23:22], act[21:16], act[15:0], exp[23:22], exp[21:16], exp[15:0]);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Output monitor: ready is set first, then the transfer that the next edge takes is compared.
  always @(negedge clk) begin
    logic [23:0] act;
    logic [23:0] e;
    cyc++;
    rdy = rdy_slow ? ((cyc % 4) != 0) : 1'b1;
    if (!rst) begin
      act = {pkt_vc, pkt_dt, pkt_wc};
      if (hold_chk) note(pkt_valid && act == held, "R12 hold", act, held);
      hold_chk = 1'b0;
      if (pkt_valid && rdy) begin
        if (exp_q.size() == 0) begin
          note(1'b0, "R6 stray request", act, 24'h0);
        end else begin
          e = exp_q.pop_front();
          note(act == e, {tag_of(e[21:16]), " R10 R11"}, act, e);
        end
      end else if (pkt_valid) begin
        hold_chk = 1'b1;
        held = act;
      end
    end
    if (cyc > 150000 && !done) begin
      note(1'b0, "watchdog", 24'h0, 24'h0);
      finish_run();
    end
  end

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(int mode, int fill, int fmt, int vc, bit hp, bit vp, int chunk,
                         int vbp, int height, int hsw, int hbp, int hfp, bit slow);
    c_mode = 2'(mode); c_fill = 2'(fill); c_fmt = 2'(fmt); c_vc = 2'(vc);
    c_hpol = hp; c_vpol = vp; hs = ~hp; vs = ~vp;
    c_chunk = 12'(chunk); c_vbp = 12'(vbp); c_height = 12'(height);
    c_hsw = 12'(hsw); c_hbp = 12'(hbp); c_hfp = 12'(hfp);
    rdy_slow = slow;
    ticks(3);
  endtask

  // Six lines per frame, VSYNC active on line 0 only; DE driven on every line.
  task automatic run_frame(int hact);
    for (int ln = 0; ln < 6; ln++) begin
      int idx = ln - 1;
      bit act = (ln >= 1) && (idx >= int'(c_vbp)) && (idx < int'(c_vbp) + int'(c_height));
      if (ln == 0) expect_pkt('h01, 0);
      else begin
        if (ln == 1 && c_mode == 2'd0) expect_pkt('h11, 0);
        expect_pkt('h21, 0);
      end
      if (c_mode == 2'd0) expect_pkt('h31, 0);
      if (act) begin
        int rem = hact;
        while (rem > 0) begin
          int n = (rem < int'(c_chunk)) ? rem : int'(c_chunk);
          expect_pkt({2'(c_fmt), 4'hE}, bytes_for(int'(c_fmt), n));
          rem -= n;
        end
        if (c_fill == 2'd1 || c_fill == 2'd2)
          expect_pkt((c_fill == 2'd1) ? 'h19 : 'h09,
                     (c_mode == 2'd2) ? int'(c_hsw) + int'(c_hbp) + int'(c_hfp) : int'(c_hfp));
      end
      hs = c_hpol;
      if (ln == 0) vs = c_vpol;
      if (ln == 1) vs = ~c_vpol;
      ticks(int'(c_hsw));
      hs = ~c_hpol;
      ticks(int'(c_hbp));
      de = 1'b1;
      ticks(hact);
      de = 1'b0;
      ticks(int'(c_hfp));
    end
  endtask

  task automatic drain(string req);
    ticks(60);
    note(exp_q.size() == 0, req, 24'(exp_q.size()), 24'h0);
    exp_q.delete();
  endtask

  initial begin
    ticks(4);
    rst = 1'b0;
    ticks(1);
    note(!pkt_valid, "R1 reset idle", {23'h0, pkt_valid}, 24'h0);
    ticks(5);
    note(!pkt_valid, "R1 quiet without events", {23'h0, pkt_valid}, 24'h0);

    // Sync pulses, blanking filler, RGB888, exact chunks.
    set_cfg(0, 1, 3, 1, 1'b1, 1'b1, 4, 1, 2, 2, 3, 6, 1'b0);
    run_frame(8); run_frame(8);
    drain("R6 R12 all requests delivered (pulse mode)");

    // Sync events, null filler, RGB565, remainder chunk, active-low syncs, stalls.
    set_cfg(1, 2, 0, 2, 1'b0, 1'b0, 3, 0, 3, 2, 3, 6, 1'b1);
    run_frame(7); run_frame(7);
    drain("R2 R12 all requests delivered (event mode)");

    // Burst, low-power filler, packed 666, mixed polarity.
    set_cfg(2, 0, 1, 3, 1'b1, 1'b0, 4, 2, 2, 2, 3, 8, 1'b0);
    run_frame(8); run_frame(8);
    drain("R9 R12 all requests delivered (burst, no filler)");

    // Burst with blanking filler sized over the whole horizontal blank, loose 666.
    set_cfg(2, 1, 2, 0, 1'b1, 1'b1, 5, 1, 3, 3, 4, 7, 1'b1);
    run_frame(5); run_frame(5);
    drain("R9 R12 all requests delivered (burst, blanking)");

    // Mode 3 and fill 3, packed 666 with odd remainder.
    set_cfg(3, 3, 1, 1, 1'b1, 1'b1, 2, 0, 5, 2, 3, 6, 1'b0);
    run_frame(5); run_frame(5);
    drain("R5 R9 R12 all requests delivered (alternate codes)");

    done = 1'b1;
    finish_run();
  end

endmodule